// File: doc/BRIEF.md
# Word-Packing Shift Buffer

This block gathers 32-bit words that arrive in 128-bit input beats, each beat carrying anywhere from zero to four valid words packed from lane 0 upward. It turns them into a gap-free stream of full 128-bit output beats. Words stay in arrival order. Lane 0 of each output beat holds the oldest word still waiting. No word is lost or repeated.

Internally a staging register seven words wide holds the words not yet emitted. A three-bit fill count tracks how many words it holds. The top bit of that count means a full beat is ready. Each clock performs two actions as one step. If a beat was ready, the held contents move down by four words. The masked new words are placed directly above whatever remains. The two parts never overlap, so a bitwise OR merges them.

The output beat is the lowest four words of the staging register, and it is flagged valid while four or more words are held. The consumer must take every valid beat; the block has no output stall, and it never emits a partial beat.

Top module: `word_pack_buffer`

## Requirements
- R1: A synchronous active-high reset empties the buffer: on the first cycle after reset, `out_valid` is 0 and `out_data` is all zeros.
- R2: Output beats carry the accepted words in arrival order. Word lane k (bits 32k+31 down to 32k) of a beat follows lane k-1. Lane 0 of each beat follows lane 3 of the previous beat. No word is skipped or repeated.
- R3: `out_valid` is 1 in exactly those cycles in which four or more accepted words are held and not yet emitted.
- R4: Every cycle in which `out_valid` is 1 emits a beat, and that beat's four words are removed from the buffer. The words behind them move down to lane 0 on the next cycle, so back-to-back valid beats carry different words.
- R5: Input lanes at or above the input word count are ignored, whatever data they carry.
- R6: While `in_valid` is 0, nothing is appended, whatever `in_cnt` and `in_data` hold. A ready beat is still retired.
- R7: An input word count above 4 (values 5 to 7) is accepted as 4.
- R8: A valid input beat with a word count of 0 appends nothing and leaves a partial buffer unchanged.
- R9: The buffer never holds more than seven words. Three held words plus a four-word beat are all kept without loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat strobe |
| in_cnt | input | 3 | Number of valid words in the input beat, packed from lane 0 |
| in_data | input | 128 | Input beat, word lane k at bits 32k+31:32k |
| out_valid | output | 1 | Output beat holds four valid words |
| out_data | output | 128 | Output beat, oldest word in lane 0 |

## Verification
The hardest state to reach is a fill of seven words. Getting there needs three words left over after a retire, followed at once by a full four-word beat. An input pattern that stays aligned to four words never gets there. The stimulus therefore sweeps every pair of counts from 0 to 7, with every combination of the valid strobe. Each pair is followed by a full beat, so each leftover fill from 0 to 3 meets every kind of incoming beat. Lanes that are invalid, and beats whose strobe is low, are filled with marker patterns that would show up in the stream if they leaked.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

    parameter int WORD_W      = 32;
    parameter int LANES       = 4;
    parameter int STAGE_WORDS = 2 * LANES - 1;
    parameter int CNT_W       = $clog2(STAGE_WORDS + 1);
    parameter int BEAT_W      = WORD_W * LANES;
    parameter int STAGE_W     = WORD_W * STAGE_WORDS;

    typedef logic [CNT_W-1:0]   fill_t;
    typedef logic [BEAT_W-1:0]  beat_t;
    typedef logic [STAGE_W-1:0] stage_data_t;

    typedef struct packed {
        fill_t       fill;
        stage_data_t data;
    } stage_t;

    // Number of words an input beat contributes once its count is limited to LANES.
    function automatic fill_t clamp_words(input logic valid, input fill_t cnt);
        if (!valid)
            return '0;
        if (cnt > fill_t'(LANES))
            return fill_t'(LANES);
        return cnt;
    endfunction

endpackage

// File: rtl/wpk_lane_mask.sv
module wpk_lane_mask #(
    parameter  int WORD_W = 32,
    parameter  int LANES  = 4,
    parameter  int CNT_W  = 3,
    localparam int BEAT_W = WORD_W * LANES
) (
    input  logic              in_valid,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic [BEAT_W-1:0] in_data,
    output logic [BEAT_W-1:0] masked,
    output logic [CNT_W-1:0]  add_cnt
);

    logic [CNT_W-1:0] eff_cnt;

    // Counts above LANES saturate; a low strobe contributes nothing.
    always_comb begin
        if (!in_valid)
            eff_cnt = '0;
        else if (in_cnt > CNT_W'(LANES))
            eff_cnt = CNT_W'(LANES);
        else
            eff_cnt = in_cnt;
    end

    assign add_cnt = eff_cnt;

    // Zero every lane at or above the effective count so the later OR stays clean.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign masked[l*WORD_W +: WORD_W] =
            (CNT_W'(l) < eff_cnt) ? in_data[l*WORD_W +: WORD_W] : '0;
    end

endmodule

// File: rtl/wpk_stage_next.sv
module wpk_stage_next #(
    parameter  int WORD_W  = 32,
    parameter  int LANES   = 4,
    parameter  int CNT_W   = 3,
    localparam int BEAT_W  = WORD_W * LANES,
    localparam int STAGE_W = WORD_W * (2 * LANES - 1),
    localparam int LOW_W   = CNT_W - 1
) (
    input  logic [STAGE_W-1:0] cur_data,
    input  logic [CNT_W-1:0]   cur_fill,
    input  logic [BEAT_W-1:0]  masked,
    input  logic [CNT_W-1:0]   add_cnt,
    output logic [STAGE_W-1:0] nxt_data,
    output logic [CNT_W-1:0]   nxt_fill
);

    logic             retire;
    logic [LOW_W-1:0] leftover;
    logic [STAGE_W-1:0] kept;
    logic [STAGE_W-1:0] placed;

    // Top fill bit: a full beat is ready and leaves this cycle.
    assign retire   = cur_fill[CNT_W-1];
    assign leftover = cur_fill[LOW_W-1:0];

    always_comb begin
        kept     = retire ? (cur_data >> BEAT_W) : cur_data;
        placed   = STAGE_W'(masked) << (WORD_W * int'(leftover));
        // Disjoint fields with zeros elsewhere: OR merges them.
        nxt_data = kept | placed;
        nxt_fill = CNT_W'(leftover) + add_cnt;
    end

endmodule

// File: rtl/word_pack_buffer.sv
module word_pack_buffer
    import wpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    output logic [BEAT_W-1:0] out_data
);

    stage_t stage_q;
    stage_t stage_d;
    beat_t  masked;
    fill_t  add_cnt;

    wpk_lane_mask #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .CNT_W  (CNT_W)
    ) i_mask (
        .in_valid (in_valid),
        .in_cnt   (in_cnt),
        .in_data  (in_data),
        .masked   (masked),
        .add_cnt  (add_cnt)
    );

    wpk_stage_next #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .CNT_W  (CNT_W)
    ) i_next (
        .cur_data (stage_q.data),
        .cur_fill (stage_q.fill),
        .masked   (masked),
        .add_cnt  (add_cnt),
        .nxt_data (stage_d.data),
        .nxt_fill (stage_d.fill)
    );

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else
            stage_q <= stage_d;
    end

    assign out_data  = stage_q.data[BEAT_W-1:0];
    assign out_valid = stage_q.fill[CNT_W-1];

endmodule

// File: rtl/wpk_checker.sv
module wpk_checker
    import wpk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [CNT_W-1:0]  in_cnt,
    input logic [BEAT_W-1:0] in_data,
    input logic              out_valid,
    input logic [BEAT_W-1:0] out_data
);

    logic [CNT_W:0] held;
    logic           rst_d;

    // Word balance seen only at the ports: accepted words minus emitted words.
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)
            held <= '0;
        else
            held <= held - (out_valid ? (CNT_W+1)'(LANES) : '0)
                         + (CNT_W+1)'(clamp_words(in_valid, in_cnt));
    end

    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            assert_reset_clear_R1: assert (out_valid == 1'b0 && out_data == '0)
                else $error("R1: buffer not empty after reset");
        end
    end

    assert_valid_matches_fill_R3: assert property (
        @(posedge clk) disable iff (rst)
        out_valid == (held >= (CNT_W+1)'(LANES))
    );

    assert_no_overflow_R9: assert property (
        @(posedge clk) disable iff (rst)
        held <= (CNT_W+1)'(STAGE_WORDS)
    );

    assert_idle_holds_R6: assert property (
        @(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> $stable(out_data)
    );

    assert_empty_beat_holds_R8: assert property (
        @(posedge clk) disable iff (rst)
        (in_valid && in_cnt == '0 && !out_valid) |=> $stable(out_data)
    );

    // R4: a retired beat leaves at most three words behind unless new ones arrive.
    assert_retire_drains_R4: assert property (
        @(posedge clk) disable iff (rst)
        (out_valid && !in_valid) |=> !out_valid
    );

endmodule

bind word_pack_buffer wpk_checker i_wpk_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_cnt    (in_cnt),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_word_pack_buffer.sv
module test_word_pack_buffer;
    import wpk_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [CNT_W-1:0]  in_cnt = '0;
    logic [BEAT_W-1:0] in_data = '0;
    logic              out_valid;
    logic [BEAT_W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [WORD_W-1:0] q[$];
    logic [WORD_W-1:0] next_word = 32'h1000_0001;
    logic [BEAT_W-1:0] last_beat = '0;
    bit                last_valid = 1'b0;

    always #4 clk = ~clk;

    word_pack_buffer i_word_pack_buffer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_cnt    (in_cnt),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BEAT_W-1:0] act, input logic [BEAT_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: compare outputs with the word queue model.
    task automatic check_outputs(input string req);
        bit exp_v;
        logic [BEAT_W-1:0] exp_beat;
        exp_v = (q.size() >= LANES);
        check(out_valid == exp_v, "R3", {"valid flag ", req},
              BEAT_W'(out_valid), BEAT_W'(exp_v));
        if (exp_v) begin
            for (int l = 0; l < LANES; l++)
                exp_beat[l*WORD_W +: WORD_W] = q.pop_front();
            check(out_data == exp_beat, "R2", {"stream order ", req}, out_data, exp_beat);
            if (last_valid)
                check(out_data != last_beat, "R4", "back-to-back beats differ",
                      out_data, ~last_beat);
            last_beat = out_data;
        end
        last_valid = exp_v;
    endtask

    task automatic beat(input bit v, input int cnt, input string req);
        int take;
        @(negedge clk);
        check_outputs(req);
        take = v ? ((cnt > LANES) ? LANES : cnt) : 0;
        in_valid = v;
        in_cnt   = CNT_W'(cnt);
        for (int l = 0; l < LANES; l++) begin
            if (l < take) begin
                in_data[l*WORD_W +: WORD_W] = next_word;
                q.push_back(next_word);
                next_word++;
            end else begin
                // Marker data that must never reach the output (R5, R6).
                in_data[l*WORD_W +: WORD_W] = 32'hBAD0_0000 | WORD_W'(l) | WORD_W'(cnt << 8);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        last_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", BEAT_W'(out_valid), '0);
        check(out_data == '0, "R1", "data after reset", out_data, '0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        do_reset();

        // R9: build three leftover words, then add a full beat: seven held.
        beat(1, 3, "R9 fill3");
        beat(1, 4, "R9 add4");
        beat(0, 0, "R9 drain");
        beat(0, 0, "R9 idle");

        // R6: strobe low with nonzero count and data.
        beat(0, 4, "R6 ignored beat");
        beat(0, 2, "R6 ignored beat");
        beat(1, 1, "R6 resume");

        // R8: valid but empty beats on a partial buffer.
        beat(1, 0, "R8 empty beat");
        beat(1, 0, "R8 empty beat");
        beat(1, 2, "R8 resume");

        // R7: counts above four saturate.
        beat(1, 7, "R7 count7");
        beat(1, 5, "R7 count5");
        beat(1, 6, "R7 count6");

        // R1: reset in the middle of a partial fill.
        beat(1, 2, "R1 prefill");
        do_reset();

        // Sweep: every pair of counts and strobes, then a full beat (R5, R7, R8, R9).
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int v = 0; v < 4; v++) begin
                    beat(v[0], a, "R5 sweep");
                    beat(v[1], b, "R5 sweep");
                    beat(1, 4, "R9 sweep");
                end

        // Steady single-word trickle.
        for (int i = 0; i < 12; i++)
            beat(1, 1, "R2 trickle");

        beat(0, 0, "final");
        @(negedge clk);
        check_outputs("final");
        done = 1'b1;
        finish_run();
    end

endmodule